// File: doc/BRIEF.md
# Column-Compression Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product with no clock and no state. It works in three layers. An array of two-input AND gates forms one bit for every pair of operand bits and files that bit under the column of its combined weight. A series of reduction stages then shrinks every column. In each stage, every column chooses full adders, at most one half adder, or plain pass-through according to how far its bit count exceeds that stage's target height. A ripple carry-propagate adder sums the two rows that remain.

Each column works through its bits as an ordered list. Adders take bits from the front of the list. Leftover bits come next, then freshly made sums, and carries arriving from the column below are appended at the back. This keeps the oldest signals on the short paths and gives a tree whose depth grows with the logarithm of N, rather than a plain ripple array. Stage targets follow the series 2, 3, 4, 6, 9, 13, …, in which each target is the floor of 1.5 times the previous one. The whole schedule is worked out at elaboration by package functions, so every operand width gets a matching tree without hand edits.

Top module: `colcomp_mult`

## Requirements
- R1: For N=8, `prod` equals the arithmetic product `op_a * op_b` for every one of the 65536 operand pairs.
- R2: Operand bits a_i and b_j carry weight 2^(i+j). With one-hot operands `op_a = 1<<i` and `op_b = 1<<j`, `prod` is exactly `1<<(i+j)` (checked at N=16 for all i, j).
- R3: The product never needs a bit above 2N-1. All-ones operands give (2^N-1)^2, for example 0xFE01 at N=8 and 0xFFFE0001 at N=16, and the carry leaving the top bit of the final adder is always zero.
- R4: For N=5, the operands 5'b11010 and 5'b01001 give `prod` = 10'b0011101010.
- R5: When either operand is zero, `prod` is zero.
- R6: For N=16, `prod` matches the arithmetic product on pseudo-random operand pairs.
- R7: At N=2, where the tree has no reduction stage and the partial products go straight to the final adder, `prod` is correct for all 16 operand pairs.
- R8: Bit 0 of `prod` equals `op_a[0] & op_b[0]`, because weight column 0 holds a single partial product that passes through untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product, op_a times op_b |

## Verification
The bench aims at the places a wrong column schedule shows up. A sum or carry routed to the wrong column shifts single-bit products off their power of two. A column left with three bits loses a term, so all-ones operands give a value that is too small. A dropped carry between stages breaks products with dense operand patterns, and the full sweep at N=8 finds it. The N=2 case has no reduction stage at all, so a design that assumes at least one stage fails to build or wires the final adder to nothing. At N=16 the deepest stages are exercised, and column counts there reach their peak.

// File: rtl/cc_mult_pkg.sv
package cc_mult_pkg;

  // Upper bound on columns handled by the elaboration-time planner (N <= 64).
  localparam int CC_MAX_COLS = 128;

  // Selectors for cc_plan.
  localparam int CC_KIND_HEIGHT = 0;  // bits entering the stage in this column
  localparam int CC_KIND_CIN    = 1;  // carries arriving from the column below
  localparam int CC_KIND_FA     = 2;  // full adders used in this column
  localparam int CC_KIND_HA     = 3;  // half adders used in this column

  // Number of reduction stages: count of series targets below the tallest column.
  function automatic int cc_num_stages(input int n);
    int cnt;
    int d;
    cnt = 0;
    d   = 2;
    while (d < n) begin
      cnt++;
      d = (d * 3) / 2;
    end
    return cnt;
  endfunction

  // Target height at the output of stage st (stage 0 is the first stage).
  function automatic int cc_target(input int n, input int st);
    int idx;
    int d;
    idx = cc_num_stages(n) - 1 - st;
    d   = 2;
    for (int k = 0; k < idx; k++) d = (d * 3) / 2;
    return d;
  endfunction

  // Lowest multiplicand index contributing to column col.
  function automatic int cc_col_lo(input int n, input int col);
    return (col > n - 1) ? col - n + 1 : 0;
  endfunction

  // Partial products in column col before any reduction.
  function automatic int cc_pp_height(input int n, input int col);
    if (col > 2 * n - 2) return 0;
    return ((col < n) ? col : 2 * n - 2 - col) + 1;
  endfunction

  // Walks the reduction schedule up to stage st and reports one quantity for col.
  function automatic int cc_plan(input int n, input int st, input int col, input int kind);
    int h  [CC_MAX_COLS];
    int nh [CC_MAX_COLS];
    int prev_out;
    int total;
    int d;
    int ex;
    int nfa;
    int nha;
    for (int c = 0; c < CC_MAX_COLS; c++) begin
      h[c]  = cc_pp_height(n, c);
      nh[c] = 0;
    end
    for (int k = 0; k <= st; k++) begin
      d        = cc_target(n, k);
      prev_out = 0;
      for (int c = 0; c < 2 * n; c++) begin
        total = h[c] + prev_out;
        ex    = total - d;
        nfa   = (ex > 0) ? ex / 2 : 0;
        nha   = (ex > 0) ? ex % 2 : 0;
        if (k == st && c == col) begin
          case (kind)
            CC_KIND_HEIGHT: return h[c];
            CC_KIND_CIN:    return prev_out;
            CC_KIND_FA:     return nfa;
            default:        return nha;
          endcase
        end
        nh[c]    = total - 2 * nfa - nha;
        prev_out = nfa + nha;
      end
      for (int c = 0; c < 2 * n; c++) h[c] = nh[c];
    end
    return 0;
  endfunction

endpackage

// File: rtl/cc_ha_cell.sv
module cc_ha_cell (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/cc_fa_cell.sv
module cc_fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/cc_pp_gen.sv
module cc_pp_gen
  import cc_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]                 op_a,
  input  logic [N-1:0]                 op_b,
  output logic [2*N-1:0][2*N-1:0]      cols
);
  localparam int COLS = 2 * N;
  localparam int QW   = 2 * N;

  // Column c lists a_i & b_(c-i) for ascending i.
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int LO = cc_col_lo(N, c);
    localparam int H  = cc_pp_height(N, c);
    for (genvar k = 0; k < QW; k++) begin : g_bit
      if (k < H) begin : g_pp
        localparam int IA = LO + k;
        assign cols[c][k] = op_a[IA] & op_b[c-IA];
      end else begin : g_zero
        assign cols[c][k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cc_stage.sv
module cc_stage
  import cc_mult_pkg::*;
#(
  parameter int N   = 8,
  parameter int STG = 0
) (
  input  logic [2*N-1:0][2*N-1:0] lvl_in,
  output logic [2*N-1:0][2*N-1:0] lvl_out
);
  localparam int COLS = 2 * N;
  localparam int QW   = 2 * N;

  // Per-column ordered bit list, adder sums and adder carries.
  logic [COLS-1:0][QW-1:0] que;
  logic [COLS-1:0][QW-1:0] sums;
  logic [COLS-1:0][QW-1:0] cys;
  logic                    unused_stage;

  assign unused_stage = ^{lvl_in, que, sums, cys};

  for (genvar w = 0; w < COLS; w++) begin : g_col
    localparam int H   = cc_plan(N, STG, w, CC_KIND_HEIGHT);
    localparam int CI  = cc_plan(N, STG, w, CC_KIND_CIN);
    localparam int F   = cc_plan(N, STG, w, CC_KIND_FA);
    localparam int HA  = cc_plan(N, STG, w, CC_KIND_HA);
    localparam int USE = 3 * F + 2 * HA;
    localparam int REM = H + CI - USE;
    localparam int NXT = REM + F + HA;
    localparam int WP  = (w > 0) ? w - 1 : 0;

    // List: incoming column bits first, carries from the column below at the back.
    for (genvar i = 0; i < QW; i++) begin : g_que
      if (i < H) begin : g_own
        assign que[w][i] = lvl_in[w][i];
      end else if (i < H + CI) begin : g_carry
        assign que[w][i] = cys[WP][i-H];
      end else begin : g_zero
        assign que[w][i] = 1'b0;
      end
    end

    // Adders take bits from the front of the list.
    for (genvar j = 0; j < F; j++) begin : g_fa
      cc_fa_cell u_fa (
        .x (que[w][3*j]),
        .y (que[w][3*j+1]),
        .z (que[w][3*j+2]),
        .s (sums[w][j]),
        .c (cys[w][j])
      );
    end
    for (genvar j = 0; j < HA; j++) begin : g_ha
      cc_ha_cell u_ha (
        .x (que[w][3*F+2*j]),
        .y (que[w][3*F+2*j+1]),
        .s (sums[w][F+j]),
        .c (cys[w][F+j])
      );
    end
    for (genvar j = F + HA; j < QW; j++) begin : g_tie
      assign sums[w][j] = 1'b0;
      assign cys[w][j]  = 1'b0;
    end

    // Next list: untouched bits keep their order, new sums go to the end.
    for (genvar i = 0; i < QW; i++) begin : g_nxt
      if (i < REM) begin : g_pass
        assign lvl_out[w][i] = que[w][USE+i];
      end else if (i < NXT) begin : g_sum
        assign lvl_out[w][i] = sums[w][i-REM];
      end else begin : g_zero
        assign lvl_out[w][i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cc_cpa.sv
module cc_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] cy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      cc_ha_cell u_ha (.x(x[i]), .y(y[i]), .s(sum[i]), .c(cy[i]));
    end else begin : g_rest
      cc_fa_cell u_fa (.x(x[i]), .y(y[i]), .z(cy[i-1]), .s(sum[i]), .c(cy[i]));
    end
  end

  assign cout = cy[W-1];
endmodule

// File: rtl/colcomp_mult.sv
module colcomp_mult
  import cc_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);
  localparam int COLS   = 2 * N;
  localparam int QW     = 2 * N;
  localparam int STAGES = cc_num_stages(N);

  // Column contents before stage 0 and after every stage.
  logic [STAGES:0][COLS-1:0][QW-1:0] lvl;
  // The two rows left after compression, and the final adder's top carry.
  logic [COLS-1:0]                   row_a;
  logic [COLS-1:0]                   row_b;
  logic                              cpa_cout;
  logic                              unused_top;

  cc_pp_gen #(.N(N)) u_pp (
    .op_a (op_a),
    .op_b (op_b),
    .cols (lvl[0])
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cc_stage #(.N(N), .STG(s)) u_stage (
      .lvl_in  (lvl[s]),
      .lvl_out (lvl[s+1])
    );
  end

  for (genvar w = 0; w < COLS; w++) begin : g_rows
    assign row_a[w] = lvl[STAGES][w][0];
    assign row_b[w] = lvl[STAGES][w][1];
  end

  cc_cpa #(.W(COLS)) u_cpa (
    .x    (row_a),
    .y    (row_b),
    .sum  (prod),
    .cout (cpa_cout)
  );

  // The top carry cannot be set for an unsigned N x N product; it is dropped.
  assign unused_top = ^{lvl, cpa_cout};
endmodule

// File: rtl/colcomp_mult_chk.sv
module colcomp_mult_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod,
  input logic [2*N-1:0] row_a,
  input logic [2*N-1:0] row_b,
  input logic           cpa_cout
);
  localparam int W = 2 * N;

  logic [W-1:0] want;
  logic [W:0]   rows_sum;

  assign want     = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
  assign rows_sum = {1'b0, row_a} + {1'b0, row_b};

  always_comb begin
    a_r1_product: assert (prod == want);
    a_r1_rows_sum: assert (rows_sum == {1'b0, want});
    a_r3_no_overflow: assert (!cpa_cout);
    a_r8_lsb: assert (prod[0] == (op_a[0] & op_b[0]));
    if (op_a == '0 || op_b == '0) begin
      a_r5_zero: assert (prod == '0);
    end
  end
endmodule

bind colcomp_mult colcomp_mult_chk #(.N(N)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .prod     (prod),
  .row_a    (row_a),
  .row_b    (row_b),
  .cpa_cout (cpa_cout)
);

// File: tb/test_colcomp_mult.sv
`timescale 1ns/1ps
module test_colcomp_mult;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0]  a8  = '0, b8  = '0;  logic [15:0] p8;
  logic [4:0]  a5  = '0, b5  = '0;  logic [9:0]  p5;
  logic [15:0] a16 = '0, b16 = '0;  logic [31:0] p16;
  logic [1:0]  a2  = '0, b2  = '0;  logic [3:0]  p2;

  colcomp_mult #(.N(8))  i_colcomp_mult     (.op_a(a8),  .op_b(b8),  .prod(p8));
  colcomp_mult #(.N(5))  i_colcomp_mult_n5  (.op_a(a5),  .op_b(b5),  .prod(p5));
  colcomp_mult #(.N(16)) i_colcomp_mult_n16 (.op_a(a16), .op_b(b16), .prod(p16));
  colcomp_mult #(.N(2))  i_colcomp_mult_n2  (.op_a(a2),  .op_b(b2),  .prod(p2));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Shift-and-add reference.
  function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    logic [63:0] acc;
    acc = '0;
    for (int k = 0; k < 32; k++) if (x[k]) acc = acc + ({32'b0, y} << k);
    return acc;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // R5: zero operands everywhere give zero products.
  task automatic t_zero();
    a8 = '0; b8 = 8'hA7; a5 = 5'h1F; b5 = '0; a16 = '0; b16 = '0; a2 = 2'd3; b2 = '0;
    settle();
    chk("R5 n8",  64'(p8),  64'h0);
    chk("R5 n5",  64'(p5),  64'h0);
    chk("R5 n16", 64'(p16), 64'h0);
    chk("R5 n2",  64'(p2),  64'h0);
  endtask

  // R4: the worked 5-bit example.
  task automatic t_example();
    a5 = 5'b11010; b5 = 5'b01001;
    settle();
    chk("R4 example", 64'(p5), 64'(10'b0011101010));
  endtask

  // R1: full sweep at N=8.
  task automatic t_sweep_n8();
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        a8 = 8'(ia); b8 = 8'(ib);
        settle();
        chk("R1 sweep", 64'(p8), ref_mul(32'(ia), 32'(ib)));
      end
    end
  endtask

  // R7: N=2 has no reduction stage.
  task automatic t_sweep_n2();
    for (int ia = 0; ia < 4; ia++) begin
      for (int ib = 0; ib < 4; ib++) begin
        a2 = 2'(ia); b2 = 2'(ib);
        settle();
        chk("R7 n2", 64'(p2), 64'(ia * ib));
      end
    end
  endtask

  // R2: one-hot operands land in column i+j.
  task automatic t_walk_n16();
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        a16 = 16'(1) << i; b16 = 16'(1) << j;
        settle();
        chk("R2 weight", 64'(p16), 64'(1) << (i + j));
      end
    end
  endtask

  // R3: largest operands fill the product without overflow.
  task automatic t_all_ones();
    a8 = 8'hFF; b8 = 8'hFF; a5 = 5'h1F; b5 = 5'h1F; a16 = 16'hFFFF; b16 = 16'hFFFF;
    a2 = 2'd3; b2 = 2'd3;
    settle();
    chk("R3 n8",  64'(p8),  64'hFE01);
    chk("R3 n5",  64'(p5),  64'd961);
    chk("R3 n16", 64'(p16), 64'hFFFE0001);
    chk("R3 n2",  64'(p2),  64'd9);
  endtask

  // R6: pseudo-random pairs at N=16.
  task automatic t_random_n16();
    for (int k = 0; k < 4000; k++) begin
      a16 = 16'($urandom); b16 = 16'($urandom);
      settle();
      chk("R6 random", 64'(p16), ref_mul(32'(a16), 32'(b16)));
    end
  endtask

  // R8: bit 0 follows the lowest operand bits.
  task automatic t_lsb();
    for (int k = 0; k < 4; k++) begin
      a16 = 16'h5A5A | 16'(k & 1); b16 = 16'hC3C2 | 16'((k >> 1) & 1);
      settle();
      chk("R8 lsb", 64'(p16[0]), 64'(((k & 1) != 0) && (((k >> 1) & 1) != 0)));
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_zero();
    t_example();
    t_sweep_n2();
    t_walk_n16();
    t_all_ones();
    t_lsb();
    t_random_n16();
    t_sweep_n8();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule